// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This block holds the accumulator and the five status flags (Sign, Zero, Auxiliary-carry, Parity, Carry) of an 8-bit accumulator machine. On each cycle with the write strobe high it applies one operation to the accumulator. The operation is one of three bitwise operations (AND, OR, XOR), an unsigned compare, or one of four single-bit rotates. It then registers the new accumulator and flags together. The second operand comes either from a register byte input or from an immediate byte input, and a select line picks between them.

Each operation class follows its own flag convention. Rotates change the accumulator and Carry and leave the other flags alone. Logical operations rebuild every flag and always clear Carry. Compare rebuilds every flag from the difference of accumulator and operand but leaves the accumulator as it was. The Carry used by the through-carry rotates is the unit's own registered Carry. Software loads the accumulator by ORing an immediate into a cleared accumulator, since add, subtract and operand fetch belong to other blocks.

Top module: `acc_logic_unit`

## Requirements
- R1: `op_i` codes are 0 AND, 1 OR, 2 XOR, 3 compare, 4 rotate left, 5 rotate right, 6 rotate left through carry, 7 rotate right through carry. `imm_sel_i`=1 takes `imm_opnd_i` as the operand, and 0 takes `reg_opnd_i`.
- R2: AND writes acc & operand, sets Auxiliary-carry and clears Carry.
- R3: OR and XOR write acc | operand and acc ^ operand, and clear both Auxiliary-carry and Carry. XOR of the accumulator with itself gives 00H with Zero set.
- R4: After a logical operation, Sign is bit 7 of the result, Zero is 1 if the result is 00H, and Parity is 1 if the result has an even count of one bits.
- R5: Compare leaves the accumulator unchanged. Carry = operand > acc (unsigned), Zero = equal, Sign = bit 7 and Parity = even parity of (acc - operand) mod 256, and Auxiliary-carry = low nibble of the operand greater than low nibble of acc.
- R6: Rotate left moves every bit up one place, moves bit 7 into bit 0 and copies bit 7 into Carry.
- R7: Rotate right moves every bit down one place, moves bit 0 into bit 7 and copies bit 0 into Carry.
- R8: Rotate left through carry shifts the old Carry into bit 0 and bit 7 into Carry.
- R9: Rotate right through carry shifts the old Carry into bit 7 and bit 0 into Carry.
- R10: All four rotates leave Sign, Zero, Auxiliary-carry and Parity unchanged.
- R11: With `wr_en_i` low, the accumulator and all flags hold, whatever the other inputs are.
- R12: The results of a write appear on the outputs after the clock edge that samples the strobe. Reset (active-low, asynchronous) clears the accumulator and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Apply the operation and register the result |
| op_i | input | 3 | Operation code |
| imm_sel_i | input | 1 | 1 selects the immediate operand |
| reg_opnd_i | input | 8 | Register operand byte |
| imm_opnd_i | input | 8 | Immediate operand byte |
| acc_o | output | 8 | Accumulator |
| sign_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| aux_o | output | 1 | Auxiliary-carry flag |
| par_o | output | 1 | Parity flag |
| cy_o | output | 1 | Carry flag |

## Verification
All state sits on the ports, so a wrong accumulator or flag value is visible on the cycle right after the write that produced it. A corrupted Carry also shows up indirectly one write later: the next through-carry rotate puts it into bit 0 or bit 7 of the accumulator. A flag that a rotate or compare should have held but did not shows as a change across that single write. The bench therefore chains operations, so that each result is the starting state of the next one.

// File: rtl/alu_logic_pkg.sv
package alu_logic_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_XOR = 3'd2,
        OP_CMP = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        alu_flags_t        fl;
    } alu_state_t;
endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int DW = alu_logic_pkg::DATA_W
) (
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int DW = alu_logic_pkg::DATA_W,
    parameter int NW = alu_logic_pkg::NIB_W
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] diff_o,
    output logic          borrow_o,
    output logic          nib_borrow_o
);
    logic [DW:0] wide_d;
    logic [NW:0] nib_d;

    always_comb begin
        wide_d       = {1'b0, a_i} - {1'b0, b_i};
        nib_d        = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]};
        diff_o       = wide_d[DW-1:0];
        borrow_o     = wide_d[DW];
        nib_borrow_o = nib_d[NW];
    end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate #(
    parameter int DW = alu_logic_pkg::DATA_W
) (
    input  logic [1:0]    sel_i,
    input  logic [DW-1:0] a_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    // sel_i[0]: 0 left, 1 right; sel_i[1]: 0 circular, 1 through carry
    logic fill_l, fill_r;

    always_comb begin
        fill_l = sel_i[1] ? cy_i : a_i[DW-1];
        fill_r = sel_i[1] ? cy_i : a_i[0];
        if (sel_i[0]) begin
            res_o = {fill_r, a_i[DW-1:1]};
            cy_o  = a_i[0];
        end else begin
            res_o = {a_i[DW-2:0], fill_l};
            cy_o  = a_i[DW-1];
        end
    end
endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval #(
    parameter int DW = alu_logic_pkg::DATA_W
) (
    input  logic [DW-1:0] val_i,
    output logic          s_o,
    output logic          z_o,
    output logic          p_o
);
    always_comb begin
        s_o = val_i[DW-1];
        z_o = (val_i == '0);
        p_o = ~(^val_i);
    end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import alu_logic_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [2:0]    op_i,
    input  logic          imm_sel_i,
    input  logic [DW-1:0] reg_opnd_i,
    input  logic [DW-1:0] imm_opnd_i,
    output logic [DW-1:0] acc_o,
    output logic          sign_o,
    output logic          zero_o,
    output logic          aux_o,
    output logic          par_o,
    output logic          cy_o
);
    alu_state_t    st_q, st_d;
    logic [DW-1:0] opnd;
    logic [DW-1:0] bit_res, cmp_diff, rot_res;
    logic          cmp_cy, cmp_ac, rot_cy;
    logic          ls, lz, lp, cs, cz, cp;
    alu_op_e       op_e;

    assign op_e = alu_op_e'(op_i);
    assign opnd = imm_sel_i ? imm_opnd_i : reg_opnd_i;

    alu_bitwise #(.DW(DW)) u_bitwise (
        .sel_i(op_i[1:0]), .a_i(st_q.acc), .b_i(opnd), .res_o(bit_res)
    );

    alu_compare #(.DW(DW)) u_compare (
        .a_i(st_q.acc), .b_i(opnd), .diff_o(cmp_diff),
        .borrow_o(cmp_cy), .nib_borrow_o(cmp_ac)
    );

    alu_rotate #(.DW(DW)) u_rotate (
        .sel_i(op_i[1:0]), .a_i(st_q.acc), .cy_i(st_q.fl.cy),
        .res_o(rot_res), .cy_o(rot_cy)
    );

    alu_flag_eval #(.DW(DW)) u_flags_logic (
        .val_i(bit_res), .s_o(ls), .z_o(lz), .p_o(lp)
    );

    alu_flag_eval #(.DW(DW)) u_flags_cmp (
        .val_i(cmp_diff), .s_o(cs), .z_o(cz), .p_o(cp)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (op_e)
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.acc   = bit_res;
                    st_d.fl.s  = ls;
                    st_d.fl.z  = lz;
                    st_d.fl.p  = lp;
                    st_d.fl.ac = (op_e == OP_AND);
                    st_d.fl.cy = 1'b0;
                end
                OP_CMP: begin
                    st_d.fl.s  = cs;
                    st_d.fl.z  = cz;
                    st_d.fl.p  = cp;
                    st_d.fl.ac = cmp_ac;
                    st_d.fl.cy = cmp_cy;
                end
                default: begin
                    st_d.acc   = rot_res;
                    st_d.fl.cy = rot_cy;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign sign_o = st_q.fl.s;
    assign zero_o = st_q.fl.z;
    assign aux_o  = st_q.fl.ac;
    assign par_o  = st_q.fl.p;
    assign cy_o   = st_q.fl.cy;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(acc_o) && $stable({sign_o, zero_o, aux_o, par_o, cy_o})); // R11
    AST_ROT_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i[2]) |=> $stable({sign_o, zero_o, aux_o, par_o})); // R10
    AST_CMP_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 3'd3) |=> $stable(acc_o)); // R5
    AST_LOGIC_CY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i < 3'd3) |=> !cy_o); // R2
    AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i < 3'd3) |=> (zero_o == (acc_o == '0)) && (par_o == ~(^acc_o))); // R4
    AST_ROL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 3'd4) |=> (acc_o[0] == cy_o)); // R6
    AST_ROR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == 3'd5) |=> (acc_o[DW-1] == cy_o)); // R7
endmodule

// File: tb/acc_logic_unit_tb_top.sv
module acc_logic_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic       imm_sel_i = 1'b0;
    logic [7:0] reg_opnd_i = 8'h00;
    logic [7:0] imm_opnd_i = 8'h00;
    logic [7:0] acc_o;
    logic       sign_o, zero_o, aux_o, par_o, cy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [7:0] m_acc = 8'h00;
    logic       m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #4 clk = ~clk;

    acc_logic_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .op_i(op_i),
        .imm_sel_i(imm_sel_i), .reg_opnd_i(reg_opnd_i), .imm_opnd_i(imm_opnd_i),
        .acc_o(acc_o), .sign_o(sign_o), .zero_o(zero_o), .aux_o(aux_o),
        .par_o(par_o), .cy_o(cy_o)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "acc", acc_o, m_acc);
        chk(tag, "flags SZAPC", {3'b0, sign_o, zero_o, aux_o, par_o, cy_o},
            {3'b0, m_s, m_z, m_ac, m_p, m_cy});
    endtask

    // expected result from the requirement text
    task automatic model(input logic [2:0] op, input logic [7:0] b);
        logic [7:0] r;
        case (op)
            3'd0, 3'd1, 3'd2: begin // R2 R3 R4
                r = (op == 3'd0) ? (m_acc & b) : (op == 3'd1) ? (m_acc | b) : (m_acc ^ b);
                m_acc = r; m_s = r[7]; m_z = (r == 8'h00); m_p = ~(^r);
                m_ac = (op == 3'd0); m_cy = 1'b0;
            end
            3'd3: begin // R5
                r = m_acc - b;
                m_s = r[7]; m_z = (m_acc == b); m_p = ~(^r);
                m_cy = (b > m_acc); m_ac = (b[3:0] > m_acc[3:0]);
            end
            3'd4: begin m_cy = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end // R6
            3'd5: begin m_cy = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end // R7
            3'd6: begin r = {m_acc[6:0], m_cy}; m_cy = m_acc[7]; m_acc = r; end // R8
            default: begin r = {m_cy, m_acc[7:1]}; m_cy = m_acc[0]; m_acc = r; end // R9
        endcase
    endtask

    // one write; outputs sampled on the falling edge after the capturing edge (R12)
    task automatic do_op(input logic [2:0] op, input logic sel, input logic [7:0] b, input string tag);
        @(negedge clk);
        op_i = op; imm_sel_i = sel;
        if (sel) begin imm_opnd_i = b; reg_opnd_i = ~b; end
        else     begin reg_opnd_i = b; imm_opnd_i = ~b; end
        wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        model(op, b);
        chk_all(tag);
    endtask

    task automatic t_reset;
        m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
        chk_all("R12 reset");
    endtask

    task automatic t_logic;
        do_op(3'd1, 1'b1, 8'h5A, "R1 R3 OR imm load");
        do_op(3'd0, 1'b0, 8'h0F, "R1 R2 AND reg");
        do_op(3'd2, 1'b1, 8'hFF, "R3 R4 XOR imm");
        do_op(3'd1, 1'b0, 8'h80, "R3 R4 OR sign");
        do_op(3'd2, 1'b0, acc_o, "R3 XOR self gives zero");
        chk("R3", "zero flag after self XOR", {7'b0, zero_o}, 8'h01);
        do_op(3'd0, 1'b1, 8'hFF, "R2 AND on zero");
        do_op(3'd1, 1'b1, 8'h07, "R4 odd parity");
    endtask

    task automatic t_compare;
        do_op(3'd0, 1'b1, 8'h00, "R2 clear");
        do_op(3'd1, 1'b1, 8'h30, "R3 load 30");
        do_op(3'd3, 1'b1, 8'h05, "R5 cmp nibble borrow");
        do_op(3'd3, 1'b0, 8'h30, "R5 cmp equal");
        do_op(3'd3, 1'b1, 8'h31, "R5 cmp operand greater");
        do_op(3'd3, 1'b0, 8'h10, "R5 cmp operand less");
    endtask

    task automatic t_rotate;
        do_op(3'd0, 1'b1, 8'h00, "R2 clear");
        do_op(3'd1, 1'b1, 8'h81, "R3 load 81");
        do_op(3'd4, 1'b0, 8'h00, "R6 rotate left");
        do_op(3'd5, 1'b0, 8'h00, "R7 rotate right");
        do_op(3'd5, 1'b0, 8'h00, "R7 rotate right again");
        do_op(3'd6, 1'b0, 8'h00, "R8 rcl carry in");
        do_op(3'd6, 1'b0, 8'h00, "R8 rcl");
        do_op(3'd7, 1'b0, 8'h00, "R9 rcr");
        do_op(3'd7, 1'b0, 8'h00, "R9 rcr carry in");
    endtask

    task automatic t_flag_keep;
        do_op(3'd0, 1'b1, 8'h00, "R2 set Z AC P");
        do_op(3'd3, 1'b1, 8'h01, "R5 cmp sets carry");
        do_op(3'd8 - 3'd1, 1'b0, 8'h00, "R10 rcr keeps flags");
        chk("R10", "Z held", {7'b0, zero_o}, {7'b0, m_z});
        do_op(3'd4, 1'b0, 8'h00, "R10 rol keeps flags");
    endtask

    task automatic t_idle;
        logic [7:0] a0;
        logic [4:0] f0;
        a0 = acc_o; f0 = {sign_o, zero_o, aux_o, par_o, cy_o};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            op_i = 3'(k); imm_sel_i = k[0]; reg_opnd_i = 8'hA5; imm_opnd_i = 8'h3C;
            wr_en_i = 1'b0;
            @(negedge clk);
            chk("R11", "acc idle", acc_o, a0);
            chk("R11", "flags idle", {3'b0, sign_o, zero_o, aux_o, par_o, cy_o}, {3'b0, f0});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_logic;
        t_compare;
        t_rotate;
        t_flag_keep;
        t_idle;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule